// File: doc/BRIEF.md
# Mark/Space Pulse Modulator with End-of-Cycle Flag

This block shapes a transmit waveform for an infrared-style output. Each modulation cycle has a mark phase, with the output high, followed by a space phase, with the output low. A single down-counter times both phases. It advances once per prescaled clock tick, and the prescaler divides the clock by 1, 2, 4 or 8.

Software programs the mark and space lengths through byte-wide buffer registers. The modulator copies those buffers into its working registers only when a cycle starts or ends, so a value written in the middle of a cycle takes effect on the next cycle and the current waveform is never torn.

An end-of-cycle flag tells software when to write the next periods. The flag can raise an interrupt. It clears only through a two-step access: a status read, then an access to a period low byte. A pin stage picks what drives the pad and handles inversion and tri-state.

Register map (3-bit address, 8-bit data):

| Address | Register | Contents |
|---|---|---|
| 0 | Pin control | bit 2 pin drive enable, bit 1 polarity invert, bit 0 idle level |
| 1 | Control/status | bit 7 end-of-cycle flag (read-only), bits 6:5 prescaler select, bit 4 extended space, bit 3 baseband, bit 2 FSK select, bit 1 interrupt enable, bit 0 modulator enable |
| 2 | Mark buffer high byte | |
| 3 | Mark buffer low byte | |
| 4 | Space buffer high byte | |
| 5 | Space buffer low byte | |

Top module: `irmod`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` is 0 and `irq` is 0.
- R2: Bits 6:0 of the control/status register (address 1) read back as written. Bit 7 always shows the flag, and a write to bit 7 has no effect.
- R3: Writing the enable bit (bit 0 at address 1) from 0 to 1 while the modulator is idle starts a cycle and sets the flag on that same clock edge. The modulator output is high from the next cycle.
- R4: With mark value M, space value S and prescaler field d (bits 6:5), the output is high for (M+1)·2^d clock cycles and then low for (S+1)·2^d cycles, and this repeats. While the modulator is idle, its output is low.
- R5: The mark and space buffers (addresses 2 to 5) are copied into the working period registers only at cycle start or cycle end. A write during a cycle changes only the following cycle.
- R6: The flag is set at the end of every cycle that ends while the enable bit is 1.
- R7: The flag clears only when both steps occur in order. First, a read of address 1 must happen while the flag is 1. After that, a read or write of address 3 or address 5 clears it. An access to address 3 or 5 without that earlier read, or an access to address 2, leaves the flag set.
- R8: If the enable bit is cleared and then set again before the running cycle ends, setting it does not raise the flag. The flag rises at the end of that running cycle.
- R9: `irq` is 1 exactly when the flag is 1 and the interrupt enable (bit 1 of address 1) is 1.
- R10: `pin_oe` follows the pin-enable bit (bit 2 of address 0). The pad value is the modulator output when the enable bit is 1, and the idle-level bit (bit 0 of address 0) otherwise. It is inverted when the polarity bit (bit 1 of address 0) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rdata | output | 8 | Read data for `addr` |
| pin_o | output | 1 | Value for the transmit pad |
| pin_oe | output | 1 | Pad drive enable; 0 means high impedance |
| irq | output | 1 | End-of-cycle interrupt request |

## Verification
The period timing is tested with a table of mark, space and prescaler settings. The table includes zero-length phases, a mark value that needs the high byte, and every prescaler setting. Each setting is judged on the length of the first high run, the first low run and the second high run, so an off-by-one count, a wrong divide ratio or a missing reload each shows up separately.

The clear sequence is tested with accesses in several orders: a low-byte access without a prior status read, a status read followed by an access to the high byte, and then the correct order. This separates a flag that clears too easily from one that never clears. The buffer test writes new periods during the mark phase and checks that only the next cycle changes. The re-enable test toggles the enable bit in the middle of a cycle and checks that the flag rises at the end of that cycle and not at the toggle.

// File: rtl/irmod_pkg.sv
package irmod_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_PIN = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CSR = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_MKH = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_MKL = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_SPH = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_SPL = 3'd5;

  // control/status bit positions
  localparam int CSR_EN   = 0;
  localparam int CSR_IE   = 1;
  localparam int CSR_DIVL = 5;
  localparam int CSR_FLAG = 7;

  // pin control bit positions
  localparam int PIN_LVL = 0;
  localparam int PIN_POL = 1;
  localparam int PIN_ENA = 2;
endpackage

// File: rtl/irmod_regs.sv
module irmod_regs
  import irmod_pkg::*;
#(
  parameter int PW   = 16,
  parameter int DIVW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              flag_evt,
  output logic [DATA_W-1:0] rdata,
  output logic              ctrl_en,
  output logic              ctrl_ie,
  output logic [DIVW-1:0]   ctrl_div,
  output logic [2:0]        pin_ctrl,
  output logic [PW-1:0]     mark_buf,
  output logic [PW-1:0]     space_buf,
  output logic              en_set_wr,
  output logic              flag
);
  localparam int HW = PW - DATA_W;

  logic [2:0]        pin_q, pin_d;
  logic [6:0]        csr_q, csr_d;
  logic [HW-1:0]     mkh_q, mkh_d, sph_q, sph_d;
  logic [DATA_W-1:0] mkl_q, mkl_d, spl_q, spl_d;
  logic              flag_q, flag_d, arm_q, arm_d;
  logic              csr_wr, csr_rd, lo_acc;

  assign csr_wr = wr_en && (addr == ADR_CSR);
  assign csr_rd = rd_en && (addr == ADR_CSR);
  assign lo_acc = (rd_en || wr_en) && ((addr == ADR_MKL) || (addr == ADR_SPL));

  always_comb begin
    pin_d  = pin_q;
    csr_d  = csr_q;
    mkh_d  = mkh_q;
    mkl_d  = mkl_q;
    sph_d  = sph_q;
    spl_d  = spl_q;
    flag_d = flag_q;
    arm_d  = arm_q;
    if (wr_en) begin
      case (addr)
        ADR_PIN: pin_d = wdata[2:0];
        ADR_CSR: csr_d = wdata[6:0];
        ADR_MKH: mkh_d = wdata[HW-1:0];
        ADR_MKL: mkl_d = wdata;
        ADR_SPH: sph_d = wdata[HW-1:0];
        ADR_SPL: spl_d = wdata;
        default: ;
      endcase
    end
    if (csr_rd && flag_q) arm_d = 1'b1;
    if (csr_wr && (wdata[CSR_EN] != csr_q[CSR_EN])) arm_d = 1'b0;
    if (lo_acc && arm_q) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end
    if (flag_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      csr_q  <= '0;
      mkh_q  <= '0;
      mkl_q  <= '0;
      sph_q  <= '0;
      spl_q  <= '0;
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      pin_q  <= pin_d;
      csr_q  <= csr_d;
      mkh_q  <= mkh_d;
      mkl_q  <= mkl_d;
      sph_q  <= sph_d;
      spl_q  <= spl_d;
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  always_comb begin
    case (addr)
      ADR_PIN: rdata = {5'd0, pin_q};
      ADR_CSR: rdata = {flag_q, csr_q};
      ADR_MKH: rdata = DATA_W'(mkh_q);
      ADR_MKL: rdata = mkl_q;
      ADR_SPH: rdata = DATA_W'(sph_q);
      ADR_SPL: rdata = spl_q;
      default: rdata = '0;
    endcase
  end

  assign en_set_wr = csr_wr && wdata[CSR_EN] && !csr_q[CSR_EN];
  assign ctrl_en   = csr_q[CSR_EN];
  assign ctrl_ie   = csr_q[CSR_IE];
  assign ctrl_div  = csr_q[CSR_DIVL +: DIVW];
  assign pin_ctrl  = pin_q;
  assign mark_buf  = {mkh_q, mkl_q};
  assign space_buf = {sph_q, spl_q};
  assign flag      = flag_q;
endmodule

// File: rtl/irmod_timer.sv
module irmod_timer #(
  parameter int PW   = 16,
  parameter int DIVW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            start_req,
  input  logic [DIVW-1:0] div,
  input  logic [PW-1:0]   mark_buf,
  input  logic [PW-1:0]   space_buf,
  output logic            active,
  output logic            mod_out,
  output logic            cyc_end,
  output logic            flag_evt
);
  localparam int PSW = (1 << DIVW) - 1;

  logic [PSW-1:0] ps_q, ps_d, ps_mask;
  logic [PW-1:0]  cnt_q, cnt_d, sp_q, sp_d;
  logic           act_q, act_d, mark_q, mark_d;
  logic           tick, start;

  always_comb begin
    for (int i = 0; i < PSW; i++) ps_mask[i] = (i < int'(div));
  end

  assign tick    = act_q && ((ps_q & ps_mask) == ps_mask);
  assign start   = start_req && !act_q;
  assign cyc_end = tick && !mark_q && (cnt_q == '0);

  always_comb begin
    ps_d   = ps_q;
    cnt_d  = cnt_q;
    sp_d   = sp_q;
    act_d  = act_q;
    mark_d = mark_q;
    if (start) begin
      act_d  = 1'b1;
      mark_d = 1'b1;
      cnt_d  = mark_buf;
      sp_d   = space_buf;
      ps_d   = '0;
    end else if (act_q) begin
      ps_d = ps_q + 1'b1;
      if (tick) begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (mark_q) begin
          mark_d = 1'b0;
          cnt_d  = sp_q;
        end else if (en) begin
          mark_d = 1'b1;
          cnt_d  = mark_buf;
          sp_d   = space_buf;
        end else begin
          act_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= '0;
      cnt_q  <= '0;
      sp_q   <= '0;
      act_q  <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      ps_q   <= ps_d;
      cnt_q  <= cnt_d;
      sp_q   <= sp_d;
      act_q  <= act_d;
      mark_q <= mark_d;
    end
  end

  assign active   = act_q;
  assign mod_out  = act_q && mark_q;
  assign flag_evt = start || (cyc_end && en);
endmodule

// File: rtl/irmod_pin.sv
module irmod_pin
  import irmod_pkg::*;
(
  input  logic       sel_mod,
  input  logic       mod_out,
  input  logic [2:0] pin_ctrl,
  output logic       pin_o,
  output logic       pin_oe
);
  logic src;

  assign src    = sel_mod ? mod_out : pin_ctrl[PIN_LVL];
  assign pin_o  = pin_ctrl[PIN_ENA] && (src ^ pin_ctrl[PIN_POL]);
  assign pin_oe = pin_ctrl[PIN_ENA];
endmodule

// File: rtl/irmod.sv
module irmod
  import irmod_pkg::*;
#(
  parameter int PW   = 16,
  parameter int DIVW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rdata,
  output logic              pin_o,
  output logic              pin_oe,
  output logic              irq
);
  logic [1:0]      rst_sync;
  logic            rst_ns;
  logic            ctrl_en, ctrl_ie, en_set_wr, flag;
  logic [DIVW-1:0] ctrl_div;
  logic [2:0]      pin_ctrl;
  logic [PW-1:0]   mark_buf, space_buf;
  logic            active, mod_out, cyc_end, flag_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  irmod_regs #(.PW(PW), .DIVW(DIVW)) u_regs (
    .clk(clk), .rst_n(rst_ns), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .wr_en(wr_en), .flag_evt(flag_evt), .rdata(rdata),
    .ctrl_en(ctrl_en), .ctrl_ie(ctrl_ie), .ctrl_div(ctrl_div),
    .pin_ctrl(pin_ctrl), .mark_buf(mark_buf), .space_buf(space_buf),
    .en_set_wr(en_set_wr), .flag(flag)
  );

  irmod_timer #(.PW(PW), .DIVW(DIVW)) u_tmr (
    .clk(clk), .rst_n(rst_ns), .en(ctrl_en), .start_req(en_set_wr),
    .div(ctrl_div), .mark_buf(mark_buf), .space_buf(space_buf),
    .active(active), .mod_out(mod_out), .cyc_end(cyc_end),
    .flag_evt(flag_evt)
  );

  irmod_pin u_pin (
    .sel_mod(ctrl_en), .mod_out(mod_out), .pin_ctrl(pin_ctrl),
    .pin_o(pin_o), .pin_oe(pin_oe)
  );

  assign irq = flag && ctrl_ie;
endmodule

// File: rtl/irmod_chk.sv
module irmod_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       rd_en,
  input logic       wr_en,
  input logic       en_set_wr,
  input logic       active,
  input logic       cyc_end,
  input logic       flag_evt,
  input logic       flag,
  input logic       ctrl_en,
  input logic       mod_out,
  input logic       irq
);
  assert_start_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set_wr && !active) |=> flag);

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mod_out);

  assert_cycle_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && ctrl_en) |=> flag);

  assert_clear_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past((rd_en || wr_en) && ((addr == 3'd3) || (addr == 3'd5))));

  assert_reenable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set_wr && active && !cyc_end) |=> (flag == $past(flag)));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(flag_evt || (wr_en && (addr == 3'd1))));
endmodule

bind irmod irmod_chk u_chk (
  .clk(clk), .rst_n(rst_ns), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .en_set_wr(en_set_wr), .active(active), .cyc_end(cyc_end),
  .flag_evt(flag_evt), .flag(flag), .ctrl_en(ctrl_en), .mod_out(mod_out),
  .irq(irq)
);

// File: tb/irmod_bench.sv
`timescale 1ns/1ps
module irmod_bench;
  logic       clk, rst_n, rd_en, wr_en;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic       pin_o, pin_oe, irq;
  int n_tests, n_fail;

  irmod u_irmod (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en),
    .wr_en(wr_en), .rdata(rdata), .pin_o(pin_o), .pin_oe(pin_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // mark, space, prescaler select
  localparam logic [33:0] VECS [6] = '{
    {16'd2,   16'd1, 2'd0},
    {16'd0,   16'd0, 2'd0},
    {16'd5,   16'd3, 2'd1},
    {16'd1,   16'd4, 2'd2},
    {16'd3,   16'd0, 2'd3},
    {16'd256, 16'd1, 2'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_periods(input int m, input int s);
    bus_wr(3'd2, 8'(m >> 8));
    bus_wr(3'd3, 8'(m));
    bus_wr(3'd4, 8'(s >> 8));
    bus_wr(3'd5, 8'(s));
  endtask

  task automatic capture(output int r0, output int r1, output int r2);
    int runs [3];
    int idx = 0;
    int len = 1;
    logic cur = pin_o;
    while (idx < 3) begin
      @(negedge clk);
      if (pin_o == cur) len++;
      else begin
        runs[idx] = len;
        idx++;
        cur = pin_o;
        len = 1;
      end
    end
    r0 = runs[0]; r1 = runs[1]; r2 = runs[2];
  endtask

  task automatic stop_mod();
    bus_wr(3'd1, 8'h00);
    repeat (600) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int r0, r1, r2;
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    #20;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      bus_rd(3'(a), v);
      check(v == 8'h00, "R1 reset register", int'(v), 0);
    end
    check(pin_oe == 1'b0, "R1 pin_oe", int'(pin_oe), 0);
    check(irq == 1'b0, "R1 irq", int'(irq), 0);

    // R2 control readback, flag bit not writable
    bus_wr(3'd1, 8'h7E);
    bus_rd(3'd1, v);
    check(v == 8'h7E, "R2 readback", int'(v), 'h7E);
    bus_wr(3'd1, 8'hFE);
    bus_rd(3'd1, v);
    check(v == 8'h7E, "R2 flag write ignored", int'(v), 'h7E);
    bus_wr(3'd1, 8'h00);

    // R10 pin stage with modulator disabled
    bus_wr(3'd0, 8'h05);
    check(pin_oe == 1'b1 && pin_o == 1'b1, "R10 level high", int'({pin_oe, pin_o}), 3);
    bus_wr(3'd0, 8'h07);
    check(pin_o == 1'b0, "R10 level inverted", int'(pin_o), 0);
    bus_wr(3'd0, 8'h03);
    check(pin_oe == 1'b0, "R10 pin disabled", int'(pin_oe), 0);
    bus_wr(3'd0, 8'h04);

    // R4 period table
    foreach (VECS[i]) begin
      int m = int'(VECS[i][33:18]);
      int s = int'(VECS[i][17:2]);
      int d = int'(VECS[i][1:0]);
      set_periods(m, s);
      bus_wr(3'd1, {1'b0, 2'(d), 5'b00001});
      capture(r0, r1, r2);
      check(r0 == ((m + 1) << d), "R4 mark length", r0, (m + 1) << d);
      check(r1 == ((s + 1) << d), "R4 space length", r1, (s + 1) << d);
      check(r2 == ((m + 1) << d), "R4 second mark", r2, (m + 1) << d);
      stop_mod();
    end
    check(pin_o == 1'b0, "R4 idle output low", int'(pin_o), 0);

    // R3, R7, R9 flag set and clear sequence
    set_periods(20, 20);
    bus_wr(3'd1, 8'h03);
    check(irq == 1'b1, "R3 flag at start (via irq, R9)", int'(irq), 1);
    bus_rd(3'd3, v);
    check(irq == 1'b1, "R7 no clear without status read", int'(irq), 1);
    bus_rd(3'd1, v);
    check(v[7] == 1'b1, "R3 flag reads 1", int'(v[7]), 1);
    bus_rd(3'd2, v);
    check(irq == 1'b1, "R7 high byte does not clear", int'(irq), 1);
    bus_rd(3'd5, v);
    check(irq == 1'b0, "R7 clear after status read", int'(irq), 0);
    bus_rd(3'd1, v);
    check(v[7] == 1'b0, "R7 flag reads 0", int'(v[7]), 0);

    // R8 re-enable in mid-cycle
    bus_wr(3'd1, 8'h02);
    bus_wr(3'd1, 8'h03);
    repeat (2) @(negedge clk);
    check(irq == 1'b0, "R8 no flag on re-enable", int'(irq), 0);
    repeat (45) @(negedge clk);
    check(irq == 1'b1, "R8 flag at end of running cycle", int'(irq), 1);

    // R6 flag on each cycle end
    bus_rd(3'd1, v);
    bus_rd(3'd5, v);
    check(irq == 1'b0, "R6 flag cleared", int'(irq), 0);
    repeat (45) @(negedge clk);
    check(irq == 1'b1, "R6 flag at next cycle end", int'(irq), 1);

    // R9 interrupt enable gating
    bus_wr(3'd1, 8'h01);
    bus_rd(3'd1, v);
    check(v[7] == 1'b1 && irq == 1'b0, "R9 irq masked", int'({v[7], irq}), 2);
    stop_mod();

    // R5 buffers taken at boundaries only
    set_periods(3, 3);
    bus_wr(3'd1, 8'h01);
    fork
      capture(r0, r1, r2);
      begin
        @(negedge clk);
        bus_wr(3'd3, 8'd7);
        bus_wr(3'd5, 8'd5);
      end
    join
    check(r0 == 4, "R5 current mark unchanged", r0, 4);
    check(r1 == 4, "R5 current space unchanged", r1, 4);
    check(r2 == 8, "R5 new mark next cycle", r2, 8);
    stop_mod();

    // R10 polarity applied to modulator output
    set_periods(3, 3);
    bus_wr(3'd0, 8'h06);
    bus_wr(3'd1, 8'h01);
    check(pin_o == 1'b0, "R10 inverted mark", int'(pin_o), 0);
    repeat (4) @(negedge clk);
    check(pin_o == 1'b1, "R10 inverted space", int'(pin_o), 1);
    stop_mod();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule